// File: doc/BRIEF.md
# Byte-Wide One-Time-Programmable Memory Bus-Mode Model

A synthesizable behavioural model of the control side of a byte-wide one-time-programmable memory, meant for testbenches and emulation platforms. Each cycle it turns the bus controls into one operating mode. The controls are an active-low chip enable, an active-low output enable, a flag for the programming supply and a flag for high voltage on the signature address pin. From that mode it decides whether the data bus is driven and with what.

Electrical levels are digital flags. A small array of flops stands in for the full array, and the full-width address aliases onto it. Programming is one-way: cells start erased to all ones, and a write can only clear bits. A write is committed on the rising edge of chip enable, and only when the low pulse lasted long enough. A pulse that is too short writes nothing and raises a one-cycle error flag. A signature mode returns fixed manufacturer and device codes, selected by address bit 0.

Top module: `otp_bus_ctrl`

## Requirements
- R1: With `vpp_on_i`=0 and `ce_ni`=1 (standby), `data_oe_o`=0 and `data_o`=0x00. Whenever `data_oe_o`=0, `data_o` reads 0x00.
- R2: With `vpp_on_i`=0, `ce_ni`=0 and `oe_ni`=1 (output off), `data_oe_o`=0.
- R3: With `vpp_on_i`=0, `ce_ni`=0 and `oe_ni`=0, and outside signature mode, the block drives the byte stored at cell `addr_i[ARR_AW-1:0]`. Upper address bits alias.
- R4: Signature mode is the R3 condition with `hv_sel_i`=1 and `addr_i[ADDR_W-1:1]`=0. It drives 0x1E when `addr_i[0]`=0 and 0x0B when `addr_i[0]`=1, in place of the array.
- R5: With `hv_sel_i`=1 but any of `addr_i[ADDR_W-1:1]` set, the R3 read applies.
- R6: With `vpp_on_i`=1, `ce_ni`=0 and `oe_ni`=1 (program), the bus floats. If this mode held on at least MIN_PULSE consecutive clock edges, the first edge that sees `ce_ni`=1 afterwards stores old AND data. Address and data are taken from the last program edge, and the result is visible from the next cycle.
- R7: A program run of fewer than MIN_PULSE edges ended by `ce_ni` rising writes nothing. `pulse_err_o` is then 1 for exactly the cycle after that edge.
- R8: With `vpp_on_i`=1 and `oe_ni`=0 (verify, either `ce_ni`), the block drives the stored byte of the addressed cell.
- R9: With `vpp_on_i`=1, `ce_ni`=1 and `oe_ni`=1 (inhibit), the bus floats and the array is unchanged unless a program pulse ends at that edge.
- R10: After reset every cell reads 0xFF and `pulse_err_o`=0.
- R11: A program run left while `ce_ni` stays 0 (through `oe_ni` falling or `vpp_on_i` dropping) writes nothing and raises no error.
- R12: `mode_o` encodes the mode as follows: standby 0, output off 1, read 2, signature 3, program 4, verify 5, inhibit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| vpp_on_i | input | 1 | Programming supply present |
| hv_sel_i | input | 1 | High voltage on the signature address pin |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Program data |
| data_o | output | 8 | Read data, 0x00 when not driven |
| data_oe_o | output | 1 | Data bus driven |
| mode_o | output | 3 | Decoded mode (R12) |
| pulse_err_o | output | 1 | Short program pulse, one cycle |

## Verification
The mode decode and output multiplexer are combinational, so a wrong decode shows on `mode_o`, `data_oe_o` and `data_o` in the same cycle the inputs change. A wrong pulse count or a wrong latched address or data stays hidden until the pulse ends. It then shows either as `pulse_err_o` in the following cycle or as a wrong byte at the next read or verify of that cell. A bit that a write sets instead of clears shows at the first access to that cell after the write.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    MD_STANDBY   = 3'd0,
    MD_OUT_OFF   = 3'd1,
    MD_READ      = 3'd2,
    MD_SIGNATURE = 3'd3,
    MD_PROGRAM   = 3'd4,
    MD_VERIFY    = 3'd5,
    MD_INHIBIT   = 3'd6
  } mode_e;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_on_i,
  input  logic              hv_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mode_e             mode_o
);
  logic upper_zero;
  assign upper_zero = (addr_i[ADDR_W-1:1] == '0);

  always_comb begin
    if (vpp_on_i) begin
      if (!oe_ni)      mode_o = MD_VERIFY;
      else if (!ce_ni) mode_o = MD_PROGRAM;
      else             mode_o = MD_INHIBIT;
    end else if (ce_ni) begin
      mode_o = MD_STANDBY;
    end else if (oe_ni) begin
      mode_o = MD_OUT_OFF;
    end else if (hv_sel_i && upper_zero) begin
      mode_o = MD_SIGNATURE;
    end else begin
      mode_o = MD_READ;
    end
  end
endmodule

// File: rtl/otp_prog_timer.sv
module otp_prog_timer #(
  parameter int MIN_PULSE = 5,
  parameter int ARR_AW    = 4,
  parameter int DW        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              ce_ni,
  input  logic [ARR_AW-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  output logic              wr_en_o,
  output logic [ARR_AW-1:0] wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_PULSE);

  logic [CNT_W-1:0] cnt_q;
  logic             prog_q;
  logic             pulse_end;

  // ce rising right after a program edge closes the pulse
  assign pulse_end = prog_q && ce_ni;
  assign wr_en_o   = pulse_end && (cnt_q >= CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      prog_q    <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      err_o     <= 1'b0;
    end else begin
      prog_q <= prog_i;
      err_o  <= pulse_end && (cnt_q < CNT_MAX);
      if (prog_i) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ARR_AW = 4,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ARR_AW-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [ARR_AW-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o
);
  localparam int DEPTH = 1 << ARR_AW;

  logic [DW-1:0] cell_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cell_q[g] <= '1;
      end else if (wr_en_i && (wr_addr_i == ARR_AW'(g))) begin
        cell_q[g] <= cell_q[g] & wr_data_i;  // one-way: bits only clear
      end
    end
  end

  assign rd_data_o = cell_q[rd_addr_i];
endmodule

// File: rtl/otp_bus_ctrl.sv
module otp_bus_ctrl
  import otp_pkg::*;
#(
  parameter int          ADDR_W    = 19,
  parameter int          ARR_AW    = 4,
  parameter int          MIN_PULSE = 5,
  parameter logic [7:0]  MFR_CODE  = 8'h1E,
  parameter logic [7:0]  DEV_CODE  = 8'h0B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_on_i,
  input  logic              hv_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic [2:0]        mode_o,
  output logic              pulse_err_o
);
  localparam int DW = 8;

  mode_e             mode;
  logic              wr_en;
  logic [ARR_AW-1:0] wr_addr;
  logic [DW-1:0]     wr_data;
  logic [DW-1:0]     arr_rd;

  otp_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .vpp_on_i (vpp_on_i),
    .hv_sel_i (hv_sel_i),
    .addr_i   (addr_i),
    .mode_o   (mode)
  );

  otp_prog_timer #(.MIN_PULSE(MIN_PULSE), .ARR_AW(ARR_AW), .DW(DW)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prog_i    (mode == MD_PROGRAM),
    .ce_ni     (ce_ni),
    .addr_i    (addr_i[ARR_AW-1:0]),
    .data_i    (data_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .err_o     (pulse_err_o)
  );

  otp_cell_array #(.ARR_AW(ARR_AW), .DW(DW)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (addr_i[ARR_AW-1:0]),
    .rd_data_o (arr_rd)
  );

  always_comb begin
    unique case (mode)
      MD_READ, MD_VERIFY: begin
        data_oe_o = 1'b1;
        data_o    = arr_rd;
      end
      MD_SIGNATURE: begin
        data_oe_o = 1'b1;
        data_o    = addr_i[0] ? DEV_CODE : MFR_CODE;
      end
      default: begin
        data_oe_o = 1'b0;
        data_o    = '0;
      end
    endcase
  end

  assign mode_o = mode;
endmodule

// File: rtl/otp_bus_ctrl_chk.sv
module otp_bus_ctrl_chk #(
  parameter int         ADDR_W   = 19,
  parameter logic [7:0] MFR_CODE = 8'h1E
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              vpp_on_i,
  input logic              hv_sel_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        data_o,
  input logic              data_oe_o,
  input logic              pulse_err_o,
  input logic [7:0]        arr_rd
);
  a_r1_standby_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpp_on_i && ce_ni) |-> (!data_oe_o && data_o == 8'h00));

  a_r2_out_off_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpp_on_i && !ce_ni && oe_ni) |-> !data_oe_o);

  a_r4_mfr_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpp_on_i && !ce_ni && !oe_ni && hv_sel_i && addr_i[ADDR_W-1:1] == '0 && !addr_i[0])
      |-> (data_oe_o && data_o == MFR_CODE));

  a_r6_no_bit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(addr_i) |-> ((arr_rd & ~$past(arr_rd)) == 8'h00));

  a_r7_err_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_err_o && $stable(addr_i)) |-> $stable(arr_rd));

  a_r7_err_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_err_o |=> !pulse_err_o);

  a_r9_inhibit_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_on_i && ce_ni && oe_ni) |-> !data_oe_o);
endmodule

bind otp_bus_ctrl otp_bus_ctrl_chk #(.ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_ni       (ce_ni),
  .oe_ni       (oe_ni),
  .vpp_on_i    (vpp_on_i),
  .hv_sel_i    (hv_sel_i),
  .addr_i      (addr_i),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o),
  .pulse_err_o (pulse_err_o),
  .arr_rd      (arr_rd)
);

// File: tb/tb_otp_bus_ctrl.sv
`timescale 1ns/1ps
module tb_otp_bus_ctrl;
  localparam int ADDR_W    = 19;
  localparam int ARR_AW    = 4;
  localparam int DEPTH     = 1 << ARR_AW;
  localparam int MIN_PULSE = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_ni = 1'b1, oe_ni = 1'b1, vpp_on_i = 1'b0, hv_sel_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [7:0]        data_i = '0;
  logic [7:0]        data_o;
  logic              data_oe_o;
  logic [2:0]        mode_o;
  logic              pulse_err_o;

  int n_vec = 0;
  int n_bad = 0;

  otp_bus_ctrl #(.ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .MIN_PULSE(MIN_PULSE)) dut (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .vpp_on_i, .hv_sel_i, .addr_i, .data_i,
    .data_o, .data_oe_o, .mode_o, .pulse_err_o
  );

  always #4 clk_i = ~clk_i;  // 125 MHz

  // Behavioural reference
  int ref_mem [DEPTH];
  int ref_cnt = 0;
  bit ref_prev_prog = 0;
  int ref_wa = 0, ref_wd = 0;
  bit ref_err = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (ref_mem[i]) ref_mem[i] = 255;
      ref_cnt = 0; ref_prev_prog = 0; ref_err = 0;
    end else begin
      bit now_prog;
      bit nerr;
      now_prog = vpp_on_i && !ce_ni && oe_ni;
      nerr = 0;
      if (ref_prev_prog && ce_ni) begin
        if (ref_cnt >= MIN_PULSE) ref_mem[ref_wa] = ref_mem[ref_wa] & ref_wd;
        else nerr = 1;
      end
      if (now_prog) begin
        ref_cnt = (ref_cnt < MIN_PULSE) ? ref_cnt + 1 : MIN_PULSE;
        ref_wa = int'(addr_i[ARR_AW-1:0]);
        ref_wd = int'(data_i);
      end else begin
        ref_cnt = 0;
      end
      ref_prev_prog = now_prog;
      ref_err = nerr;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
    end
  endtask

  // Per-cycle comparison, sampled at negedge
  always @(negedge clk_i) if (rst_ni) begin
    int  em, ed;
    bit  eoe;
    string tag;
    if (vpp_on_i) begin
      if (!oe_ni)      begin em = 5; tag = "R8"; end
      else if (!ce_ni) begin em = 4; tag = "R6"; end
      else             begin em = 6; tag = "R9"; end
    end else if (ce_ni) begin em = 0; tag = "R1"; end
    else if (oe_ni)     begin em = 1; tag = "R2"; end
    else if (hv_sel_i && addr_i[ADDR_W-1:1] == 0) begin em = 3; tag = "R4"; end
    else begin em = 2; tag = hv_sel_i ? "R5" : "R3"; end
    eoe = (em == 2 || em == 3 || em == 5);
    if (em == 3) ed = addr_i[0] ? 8'h0B : 8'h1E;
    else if (eoe) ed = ref_mem[int'(addr_i[ARR_AW-1:0])];
    else ed = 0;
    check("R12 mode", int'(mode_o), em);
    check({tag, " oe"}, int'(data_oe_o), int'(eoe));
    check({tag, " data"}, int'(data_o), ed);
    check("R7 err", int'(pulse_err_o), int'(ref_err));
  end

  task automatic drive(bit ce, bit oe, bit vpp, bit hv, logic [ADDR_W-1:0] a, logic [7:0] d);
    @(posedge clk_i); #2;
    ce_ni = ce; oe_ni = oe; vpp_on_i = vpp; hv_sel_i = hv; addr_i = a; data_i = d;
  endtask

  task automatic read_chk(string tag, logic [ADDR_W-1:0] a, bit hv, int exp);
    drive(0, 0, 0, hv, a, 8'h00);
    @(negedge clk_i);
    check(tag, int'(data_o), exp);
  endtask

  task automatic prog_pulse(logic [ADDR_W-1:0] a, logic [7:0] d, int len);
    drive(1, 1, 1, 0, a, d);
    for (int i = 0; i < len; i++) drive(0, 1, 1, 0, a, d);
    drive(1, 1, 1, 0, a, d);  // ce rises: commit edge follows
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    // R10: erased after reset
    for (int i = 0; i < DEPTH; i++) read_chk("R10 erased", ADDR_W'(i), 0, 8'hFF);
    @(negedge clk_i) check("R10 err", int'(pulse_err_o), 0);

    // R6: full pulse then AND semantics
    prog_pulse(19'd3, 8'hA5, MIN_PULSE);
    drive(1, 1, 1, 0, 19'd3, 8'h00);
    read_chk("R6 first write", 19'd3, 0, 8'hA5);
    prog_pulse(19'd3, 8'h5F, MIN_PULSE + 3);
    drive(1, 1, 0, 0, 19'd3, 8'h00);
    read_chk("R6 and write", 19'd3, 0, 8'h05);
    read_chk("R3 alias", 19'h00013, 0, 8'h05);

    // R7: short pulse
    drive(1, 1, 1, 0, 19'd5, 8'h00);
    for (int i = 0; i < MIN_PULSE - 1; i++) drive(0, 1, 1, 0, 19'd5, 8'h00);
    drive(1, 1, 1, 0, 19'd5, 8'h00);
    @(posedge clk_i); @(negedge clk_i);
    check("R7 err high", int'(pulse_err_o), 1);
    @(negedge clk_i);
    check("R7 err low", int'(pulse_err_o), 0);
    read_chk("R7 no write", 19'd5, 0, 8'hFF);

    // R9 inhibit / R8 verify
    drive(1, 1, 1, 0, 19'd3, 8'h00);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) check("R9 float", int'(data_oe_o), 0);
    drive(1, 0, 1, 0, 19'd3, 8'h00);
    @(negedge clk_i) check("R8 verify", int'(data_o), 8'h05);
    drive(0, 0, 1, 0, 19'd3, 8'h00);
    @(negedge clk_i) check("R8 verify ce low", int'(data_o), 8'h05);

    // R4 / R5 signature
    read_chk("R4 mfr", 19'd0, 1, 8'h1E);
    read_chk("R4 dev", 19'd1, 1, 8'h0B);
    read_chk("R5 upper bit", 19'h00012, 1, 8'hFF);
    read_chk("R5 alias cell 3", 19'h40003, 1, 8'h05);

    // R11 aborts: vpp drop and oe fall while ce low
    drive(1, 1, 1, 0, 19'd7, 8'h00);
    for (int i = 0; i < MIN_PULSE + 1; i++) drive(0, 1, 1, 0, 19'd7, 8'h00);
    drive(0, 1, 0, 0, 19'd7, 8'h00);
    drive(1, 1, 0, 0, 19'd7, 8'h00);
    @(posedge clk_i); @(negedge clk_i);
    check("R11 no err vpp", int'(pulse_err_o), 0);
    read_chk("R11 vpp abort", 19'd7, 0, 8'hFF);
    drive(1, 1, 1, 0, 19'd8, 8'h00);
    for (int i = 0; i < MIN_PULSE + 1; i++) drive(0, 1, 1, 0, 19'd8, 8'h00);
    drive(0, 0, 1, 0, 19'd8, 8'h00);
    drive(1, 0, 1, 0, 19'd8, 8'h00);
    @(posedge clk_i); @(negedge clk_i);
    check("R11 no err oe", int'(pulse_err_o), 0);
    read_chk("R11 oe abort", 19'd8, 0, 8'hFF);

    // Mixed stimulus, checked each cycle against the reference
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      logic [ADDR_W-1:0] a;
      r = $urandom;
      a = (r[3:2] == 2'b00) ? ADDR_W'(r[0]) : (ADDR_W'(r[22:4]) & 19'h1000F);
      drive(r[23], r[24] & r[25], r[26], r[27], a, 8'($urandom));
      repeat (int'(r[30:28])) @(posedge clk_i);
    end

    repeat (2) @(posedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule